// File: doc/BRIEF.md
# Cellular Term Matcher

This block finds one search term in a stream of 8-bit characters. It uses a fixed chain of small programmable cells. Every cell sees the same input character, which is broadcast to all of them. Each cell takes an enable from the cell before it and gives a match flag to the cell after it. A cell is set up as one of four kinds:

- a cell that matches one exact byte;
- a cell that matches a class of characters;
- a cell that accepts any single character;
- a cell that accepts any run of non-delimiter characters.

The whole term has matched when the last cell in the chain reports a match. The block then raises a one-cycle hit pulse, together with the position of that character in the stream.

Terms shorter than the chain are right-aligned. The unused leading cells are set to the variable-length kind. When a variable-length cell's enable is held high, it stays transparent, so these leading cells match any prefix. An optional word anchor gates the first cell, so that a term can only begin at the start of a word. An anchored term must fill the chain with non-transparent cells. Software programs the cells one at a time through a write port. Characters arrive one per cycle whenever `chr_valid` is high.

Top module: `term_cell_array`

## Requirements
- R1: Reset behaviour. After reset, `hit` is low, `hit_pos` is zero and the position count is zero. Each cell resets to the exact kind with pattern byte 0x00.
- R2: Exact cell. An enabled exact cell matches only when the character equals its programmed byte. A chain of exact cells therefore matches a run of consecutive characters.
- R3: Hit timing. `hit` pulses high for one cycle, in the cycle after the accepted character that completes the term. In that cycle, `hit_pos` holds that character's zero-based index among all characters accepted since reset.
- R4: Idle cycles. A cycle with `chr_valid` low changes no cell state and does not advance the position count. A term may therefore span idle gaps.
- R5: Class cell. The class is selected by `cfg_pat[1:0]`: 0 = delimiter, 1 = decimal digit (0x30–0x39), 2 = letter (0x41–0x5A or 0x61–0x7A), 3 = any non-delimiter.
- R6: Delimiter set. The delimiters are tab 0x09, LF 0x0A, CR 0x0D, and the ranges 0x20–0x2F, 0x3A–0x40, 0x5B–0x60 and 0x7B–0x7E. No other byte is a delimiter.
- R7: Single-character wildcard. An enabled single-character cell accepts any one character, delimiters included.
- R8: Variable-length wildcard. This cell passes its enable straight through, so it can match zero characters. It then keeps matching across any number of further non-delimiter characters. A delimiter ends the run.
- R9: Prefix padding. Leading variable-length cells, with the first cell's enable ungated, let a shorter term match at any position in the stream.
- R10: Word anchor. When the anchor bit is set, the first cell is enabled only for a character that begins a word. Such a character is either the first one accepted since reset or one that follows a delimiter. The anchor bit is `cfg_anchor`, captured on every write to cell 0.
- R11: Programming port. When `cfg_we` is high, the cell numbered `cfg_idx` is written. It takes its kind from `cfg_kind` (0 = exact, 1 = class, 2 = single-character wildcard, 3 = variable-length wildcard) and its pattern from `cfg_pat`. The new setting applies to characters accepted after the write cycle.
- R12: Overlapping occurrences. Overlapping occurrences each produce their own hit, so hits can occur on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chr_valid | input | 1 | A character is present this cycle |
| chr_data | input | 8 | Broadcast character |
| cfg_we | input | 1 | Cell programming strobe |
| cfg_idx | input | $clog2(NCELLS) | Cell number to program |
| cfg_kind | input | 2 | Cell kind code |
| cfg_pat | input | 8 | Pattern byte, or class code in bits 1:0 |
| cfg_anchor | input | 1 | Word-anchor bit, taken on writes to cell 0 |
| hit | output | 1 | Term completed by the previous accepted character |
| hit_pos | output | POS_W | Stream index of the completing character |

## Verification
Each cell keeps only a single match bit. A stuck or wrongly cleared bit therefore shows up as a missing or extra `hit` exactly one cycle after the character that should have completed the term. A corrupted position count shows up as a wrong `hit_pos` on the very next hit. A wrong class or delimiter decode only becomes visible when a class cell or a variable-length cell sees the affected byte. For that reason, every range edge of the delimiter set is driven between two exact cells. A fault in the anchor state appears on the first word that starts with something other than a delimiter.

// File: rtl/tca_pkg.sv
package tca_pkg;
  localparam int CHAR_W = 8;

  typedef enum logic [1:0] {
    K_EXACT = 2'd0,
    K_CLASS = 2'd1,
    K_ONE   = 2'd2,
    K_ANY   = 2'd3
  } cell_kind_e;

  localparam logic [1:0] CLS_DELIM = 2'd0;
  localparam logic [1:0] CLS_DIGIT = 2'd1;
  localparam logic [1:0] CLS_ALPHA = 2'd2;
  localparam logic [1:0] CLS_WORD  = 2'd3;

  typedef struct packed {
    logic delim;
    logic digit;
    logic alpha;
  } char_flags_t;
endpackage

// File: rtl/tca_classify.sv
module tca_classify
  import tca_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chr_valid,
  input  logic [CHAR_W-1:0] chr_data,
  output char_flags_t       flags
);
  always_comb begin
    flags.delim = (chr_data == 8'h09) || (chr_data == 8'h0A) || (chr_data == 8'h0D) ||
                  (chr_data >= 8'h20 && chr_data <= 8'h2F) ||
                  (chr_data >= 8'h3A && chr_data <= 8'h40) ||
                  (chr_data >= 8'h5B && chr_data <= 8'h60) ||
                  (chr_data >= 8'h7B && chr_data <= 8'h7E);
    flags.digit = (chr_data >= 8'h30 && chr_data <= 8'h39);
    flags.alpha = (chr_data >= 8'h41 && chr_data <= 8'h5A) ||
                  (chr_data >= 8'h61 && chr_data <= 8'h7A);
  end

  AST_CLASS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    chr_valid |-> $onehot0(flags)); // R6
endmodule

// File: rtl/tca_stream_pos.sv
module tca_stream_pos #(
  parameter int POS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chr_valid,
  input  logic             is_delim,
  output logic [POS_W-1:0] pos,
  output logic             sow
);
  logic [POS_W-1:0] pos_q, pos_d;
  logic             sow_q, sow_d;

  always_comb begin
    pos_d = pos_q;
    sow_d = sow_q;
    if (chr_valid) begin
      pos_d = pos_q + 1'b1;
      sow_d = is_delim;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      sow_q <= 1'b1;
    end else begin
      pos_q <= pos_d;
      sow_q <= sow_d;
    end
  end

  assign pos = pos_q;
  assign sow = sow_q;

  AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    chr_valid |=> pos_q == POS_W'($past(pos_q) + 1'b1)); // R3
  AST_POS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !chr_valid |=> ($stable(pos_q) && $stable(sow_q))); // R4
endmodule

// File: rtl/tca_cell.sv
module tca_cell
  import tca_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_sel,
  input  cell_kind_e        cfg_kind,
  input  logic [CHAR_W-1:0] cfg_pat,
  input  logic              chr_valid,
  input  logic [CHAR_W-1:0] chr_data,
  input  char_flags_t       flags,
  input  logic              en_in,
  output logic              out_o,
  output logic              fire_o
);
  cell_kind_e        kind_q, kind_d;
  logic [CHAR_W-1:0] pat_q, pat_d;
  logic              state_q, state_d;
  logic              class_hit;
  logic              fire;

  always_comb begin
    case (pat_q[1:0])
      CLS_DELIM: class_hit = flags.delim;
      CLS_DIGIT: class_hit = flags.digit;
      CLS_ALPHA: class_hit = flags.alpha;
      default:   class_hit = !flags.delim;
    endcase
    case (kind_q)
      K_EXACT: fire = en_in && (chr_data == pat_q);
      K_CLASS: fire = en_in && class_hit;
      K_ONE:   fire = en_in;
      default: fire = (en_in || state_q) && !flags.delim;
    endcase
    kind_d  = cfg_sel ? cfg_kind : kind_q;
    pat_d   = cfg_sel ? cfg_pat : pat_q;
    state_d = chr_valid ? fire : state_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= K_EXACT;
      pat_q   <= '0;
      state_q <= 1'b0;
    end else begin
      kind_q  <= kind_d;
      pat_q   <= pat_d;
      state_q <= state_d;
    end
  end

  assign out_o  = (kind_q == K_ANY) ? (en_in || state_q) : state_q;
  assign fire_o = fire;

  AST_EXACT_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_valid && kind_q == K_EXACT && chr_data != pat_q) |=> !state_q); // R2
  AST_ANY_DELIM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_valid && kind_q == K_ANY && flags.delim) |=> !state_q); // R8
  AST_CELL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !chr_valid |=> $stable(state_q)); // R4
endmodule

// File: rtl/term_cell_array.sv
module term_cell_array
  import tca_pkg::*;
#(
  parameter int NCELLS = 6,
  parameter int POS_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      chr_valid,
  input  logic [7:0]                chr_data,
  input  logic                      cfg_we,
  input  logic [$clog2(NCELLS)-1:0] cfg_idx,
  input  logic [1:0]                cfg_kind,
  input  logic [7:0]                cfg_pat,
  input  logic                      cfg_anchor,
  output logic                      hit,
  output logic [POS_W-1:0]          hit_pos
);
  localparam int IDX_W = $clog2(NCELLS);
  localparam int LAST  = NCELLS - 1;

  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  char_flags_t      flags;
  logic [POS_W-1:0] pos;
  logic             sow;
  logic [NCELLS-1:0] cell_en, cell_out, cell_fire;

  tca_classify u_cls (
    .clk(clk), .rst_n(rst_i_n), .chr_valid(chr_valid),
    .chr_data(chr_data), .flags(flags)
  );

  tca_stream_pos #(.POS_W(POS_W)) u_pos (
    .clk(clk), .rst_n(rst_i_n), .chr_valid(chr_valid),
    .is_delim(flags.delim), .pos(pos), .sow(sow)
  );

  logic anchor_q, anchor_d;
  logic hit_q, hit_d;
  logic [POS_W-1:0] hit_pos_q, hit_pos_d;

  assign cell_en[0] = anchor_q ? sow : 1'b1;

  for (genvar g = 0; g < NCELLS; g++) begin : g_cell
    if (g > 0) begin : g_link
      assign cell_en[g] = cell_out[g-1];
    end
    tca_cell u_cell (
      .clk(clk), .rst_n(rst_i_n),
      .cfg_sel(cfg_we && (cfg_idx == IDX_W'(g))),
      .cfg_kind(cell_kind_e'(cfg_kind)), .cfg_pat(cfg_pat),
      .chr_valid(chr_valid), .chr_data(chr_data), .flags(flags),
      .en_in(cell_en[g]), .out_o(cell_out[g]), .fire_o(cell_fire[g])
    );
  end

  always_comb begin
    anchor_d  = (cfg_we && cfg_idx == '0) ? cfg_anchor : anchor_q;
    hit_d     = chr_valid && cell_fire[LAST];
    hit_pos_d = hit_d ? pos : hit_pos_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      anchor_q  <= 1'b0;
      hit_q     <= 1'b0;
      hit_pos_q <= '0;
    end else begin
      anchor_q  <= anchor_d;
      hit_q     <= hit_d;
      hit_pos_q <= hit_pos_d;
    end
  end

  assign hit     = hit_q;
  assign hit_pos = hit_pos_q;

  AST_HIT_POSITION: assert property (@(posedge clk) disable iff (!rst_i_n)
    hit_q |-> hit_pos_q == $past(pos)); // R3
  AST_HIT_NEEDS_CHAR: assert property (@(posedge clk) disable iff (!rst_i_n)
    !chr_valid |=> !hit_q); // R4
endmodule

// File: tb/term_cell_array_test.sv
module term_cell_array_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        chr_valid;
  logic [7:0]  chr_data;
  logic        cfg_we;
  logic [2:0]  cfg_idx;
  logic [1:0]  cfg_kind;
  logic [7:0]  cfg_pat;
  logic        cfg_anchor;
  logic        hit;
  logic [15:0] hit_pos;

  int checks = 0;
  int errors = 0;
  int n_sent = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  term_cell_array #(.NCELLS(6), .POS_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .chr_valid(chr_valid), .chr_data(chr_data),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_kind(cfg_kind), .cfg_pat(cfg_pat),
    .cfg_anchor(cfg_anchor), .hit(hit), .hit_pos(hit_pos)
  );

  // term "c?t" with three leading transparent cells: {char, expected hit}
  localparam logic [8:0] TBL [19] = '{
    {8'h63,1'b0}, {8'h61,1'b0}, {8'h74,1'b1}, {8'h20,1'b0},
    {8'h63,1'b0}, {8'h75,1'b0}, {8'h74,1'b1}, {8'h20,1'b0},
    {8'h63,1'b0}, {8'h74,1'b0}, {8'h20,1'b0},
    {8'h63,1'b0}, {8'h6F,1'b0}, {8'h74,1'b1}, {8'h74,1'b0}, {8'h20,1'b0},
    {8'h63,1'b0}, {8'h2E,1'b0}, {8'h74,1'b1}
  };

  // bytes placed between 'x' and 'y' for a delimiter-class cell
  localparam logic [8:0] DTAB [16] = '{
    {8'h20,1'b1}, {8'h09,1'b1}, {8'h0A,1'b1}, {8'h0D,1'b1},
    {8'h21,1'b1}, {8'h2F,1'b1}, {8'h3A,1'b1}, {8'h40,1'b1},
    {8'h5B,1'b1}, {8'h60,1'b1}, {8'h7B,1'b1}, {8'h7E,1'b1},
    {8'h30,1'b0}, {8'h41,1'b0}, {8'h7A,1'b0}, {8'h7F,1'b0}
  };

  task automatic send(input logic [7:0] c);
    chr_data  = c;
    chr_valid = 1'b1;
    @(negedge clk);
    chr_valid = 1'b0;
    n_sent++;
  endtask

  task automatic prog(input int idx, input logic [1:0] k, input logic [7:0] p, input logic a);
    cfg_idx    = idx[2:0];
    cfg_kind   = k;
    cfg_pat    = p;
    cfg_anchor = a;
    cfg_we     = 1'b1;
    @(negedge clk);
    cfg_we     = 1'b0;
  endtask

  task automatic expect_hit(input string req, input logic e);
    checks++;
    if (hit !== e) begin
      errors++;
      $display("FAIL %s: hit=%0b expected %0b (char #%0d)", req, hit, e, n_sent - 1);
    end else if (e && hit_pos !== 16'(n_sent - 1)) begin
      errors++;
      $display("FAIL %s: hit_pos=%0d expected %0d", req, hit_pos, n_sent - 1);
    end
  endtask

  task automatic send_chk(input logic [7:0] c, input logic e, input string req);
    send(c);
    expect_hit(req, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; chr_valid = 1'b0; chr_data = '0;
    cfg_we = 1'b0; cfg_idx = '0; cfg_kind = '0; cfg_pat = '0; cfg_anchor = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    checks++;
    if (hit !== 1'b0 || hit_pos !== 16'd0) begin
      errors++;
      $display("FAIL R1: hit=%0b hit_pos=%0d expected 0 and 0", hit, hit_pos);
    end

    // R11 / R9 / R2 / R7 / R3: program "c?t" right-aligned, walk the table
    prog(0, 2'd3, 8'h00, 1'b0);
    prog(1, 2'd3, 8'h00, 1'b0);
    prog(2, 2'd3, 8'h00, 1'b0);
    prog(3, 2'd0, 8'h63, 1'b0);
    prog(4, 2'd2, 8'h00, 1'b0);
    prog(5, 2'd0, 8'h74, 1'b0);
    for (int i = 0; i < 19; i++) begin
      send_chk(TBL[i][8:1], TBL[i][0], "R2/R3/R7/R9 table");
    end

    // R4: idle gaps inside a term; R3: pulse is a single cycle
    send(8'h20);
    send_chk(8'h63, 1'b0, "R4 c");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      expect_hit("R4 idle", 1'b0);
    end
    send_chk(8'h6F, 1'b0, "R4 o");
    repeat (2) @(negedge clk);
    send_chk(8'h74, 1'b1, "R4 t after gap");
    @(negedge clk);
    expect_hit("R3 single-cycle pulse", 1'b0);

    // R6 / R5: delimiter class between exact 'x' and 'y'
    prog(3, 2'd0, 8'h78, 1'b0);
    prog(4, 2'd1, 8'h00, 1'b0);
    prog(5, 2'd0, 8'h79, 1'b0);
    for (int i = 0; i < 16; i++) begin
      send(8'h78);
      send(DTAB[i][8:1]);
      send_chk(8'h79, DTAB[i][0], "R6 delimiter set");
    end

    // R5: remaining classes
    prog(4, 2'd1, 8'h01, 1'b0);
    send(8'h78); send(8'h35); send_chk(8'h79, 1'b1, "R5 digit 5");
    send(8'h78); send(8'h61); send_chk(8'h79, 1'b0, "R5 digit vs a");
    prog(4, 2'd1, 8'h02, 1'b0);
    send(8'h78); send(8'h51); send_chk(8'h79, 1'b1, "R5 letter Q");
    send(8'h78); send(8'h33); send_chk(8'h79, 1'b0, "R5 letter vs 3");
    prog(4, 2'd1, 8'h03, 1'b0);
    send(8'h78); send(8'h33); send_chk(8'h79, 1'b1, "R5 word 3");
    send(8'h78); send(8'h20); send_chk(8'h79, 1'b0, "R5 word vs space");

    // R8: embedded variable-length wildcard "ab*c"
    prog(2, 2'd0, 8'h61, 1'b0);
    prog(3, 2'd0, 8'h62, 1'b0);
    prog(4, 2'd3, 8'h00, 1'b0);
    prog(5, 2'd0, 8'h63, 1'b0);
    send(8'h20); send(8'h61); send(8'h62);
    send_chk(8'h63, 1'b1, "R8 zero length");
    send(8'h20); send(8'h61); send(8'h62);
    send_chk(8'h78, 1'b0, "R8 run x");
    send_chk(8'h79, 1'b0, "R8 run y");
    send_chk(8'h63, 1'b1, "R8 run then c");
    send(8'h20); send(8'h61); send(8'h62);
    send_chk(8'h20, 1'b0, "R8 delimiter");
    send_chk(8'h63, 1'b0, "R8 c after delimiter");

    // R12: overlapping "aaa"
    prog(2, 2'd3, 8'h00, 1'b0);
    prog(3, 2'd0, 8'h61, 1'b0);
    prog(4, 2'd0, 8'h61, 1'b0);
    prog(5, 2'd0, 8'h61, 1'b0);
    send(8'h20);
    send_chk(8'h61, 1'b0, "R12 a1");
    send_chk(8'h61, 1'b0, "R12 a2");
    send_chk(8'h61, 1'b1, "R12 a3");
    send_chk(8'h61, 1'b1, "R12 a4 overlap");
    send_chk(8'h62, 1'b0, "R12 b");

    // R10: anchored full-width term "abcdef"
    for (int i = 0; i < 6; i++) begin
      prog(i, 2'd0, 8'(8'h61 + i), (i == 0));
    end
    send(8'h20);
    for (int i = 0; i < 5; i++) send(8'(8'h61 + i));
    send_chk(8'h66, 1'b1, "R10 word start");
    send(8'h20); send(8'h78);
    for (int i = 0; i < 5; i++) send(8'(8'h61 + i));
    send_chk(8'h66, 1'b0, "R10 mid-word blocked");
    prog(0, 2'd0, 8'h61, 1'b0);
    send(8'h20); send(8'h78);
    for (int i = 0; i < 5; i++) send(8'(8'h61 + i));
    send_chk(8'h66, 1'b1, "R10 anchor off");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule